// File: doc/BRIEF.md
# Sponge Hash and Extendable-Output Engine

This block computes a fixed-length 256-bit digest, or an output stream of any requested length, over a message of any byte length. It uses a sponge construction built on a 320-bit permutation. The state is five 64-bit words, w0 to w4. Only w0 takes part in input and output. The permutation applies one round per clock cycle and is shared by every phase of a job.

A job opens with a one-cycle `start` pulse. That pulse selects the mode and the round variant and, in extendable mode, the number of output words. The message then enters as a valid/ready stream of 64-bit blocks. The final block carries a flag and a count of its valid bytes. The block pads the message, runs the final mixing permutation, and delivers result words on a valid/ready output stream. It flags the last word and then returns to idle.

The starting state can come from a constant that the build computes at elaboration. It can also come from running the full permutation on the seed word in hardware. A parameter selects between the two, and both give the same results.

Top module: `sponge_hash_top`

## Requirements
- R1: After reset, `busy`, `msg_ready` and `out_valid` are all 0.
- R2: `start` while idle latches `mode_xof` (0 = 256-bit digest, 1 = extendable output), `fast_sel` and `out_words`. `start` while `busy` is ignored and does not change the job in progress.
- R3: The starting state is the 12-round permutation of {w0 = seed, w1..w4 = 0}. The seed, from bit 63 down, is the bytes 0x00, 0x40, 0x0C, then (12 − data rounds), then 32 bits of 256 in digest mode or 0 in extendable mode. With the precomputed start, `msg_ready` rises on the cycle after `start` is taken. Otherwise it rises 12 cycles after that.
- R4: A message block is XORed into w0, and its first byte occupies bits 63:56. A block that is not last is followed by the data rounds, and `msg_ready` returns (data rounds + 1) clock periods after the handshake. `msg_ready` and `out_valid` are never high together.
- R5: A last block with n = 0..7 valid bytes keeps bytes 0..n−1, sets byte n to 0x80 and clears all lower bytes. Data in bytes n..7 has no effect on the output.
- R6: A last block with 8 valid bytes is absorbed like any full block. An extra block holding only 0x80 in bits 63:56 follows it.
- R7: The padded final block is followed by 12 rounds. The first `out_valid` appears 13 periods after a partial last block is taken, or (data rounds + 14) periods after a full last block.
- R8: Each output word is the current w0. The data rounds run between consecutive words, so the next word appears (data rounds + 1) periods after a handshake. After the final word no rounds run, and `busy` is 0 on the next cycle.
- R9: Digest mode produces exactly four words, and `out_last` is high on the fourth.
- R10: Extendable mode produces `out_words` words, and a request of zero produces one word. `out_last` marks the final word.
- R11: With `fast_sel` = 1 the data rounds are 8, using the last 8 round constants. Otherwise they are 12. The start permutation and the final-block permutation always use 12.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (taken only while idle) |
| mode_xof | input | 1 | 0 = 256-bit digest, 1 = extendable output |
| fast_sel | input | 1 | 1 = 8 data rounds, 0 = 12 |
| out_words | input | LEN_W | Output word count for extendable mode |
| busy | output | 1 | A job is in progress |
| msg_valid | input | 1 | Message block valid |
| msg_ready | output | 1 | Engine accepts a message block |
| msg_data | input | 64 | Message block, first byte in bits 63:56 |
| msg_last | input | 1 | This block is the final one |
| msg_bytes | input | 4 | Valid bytes in the final block (0..8) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 64 | Output word |
| out_last | output | 1 | This output word is the final one |

## Verification
A wrong round constant, a wrong rotation or a wrong padding byte corrupts every later bit of state. It therefore shows on the first output word of the job, and any wrong word is reported immediately. A wrong round counter or a wrong phase transition changes when `msg_ready` or `out_valid` rises, and that shifts the gap between handshakes by at least one cycle. Any stray permutation after the final word leaves `busy` high on the next cycle, and a job that stalls ends with the watchdog reporting it.

// File: rtl/sponge_pkg.sv
package sponge_pkg;
  localparam int WORD_W      = 64;
  localparam int NWORDS      = 5;
  localparam int FULL_ROUNDS = 12;
  localparam int RND_W       = 4;
  localparam int CNT_W       = 4;
  localparam int BLK_BYTES   = WORD_W / 8;
  localparam logic [WORD_W-1:0] PAD_ONLY = {8'h80, {(WORD_W-8){1'b0}}};

  typedef logic [NWORDS-1:0][WORD_W-1:0] state_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PERM, PH_ABSORB, PH_PAD, PH_SQUEEZE
  } phase_t;

  typedef enum logic [1:0] {
    GO_ABSORB, GO_PAD, GO_SQUEEZE
  } next_t;

  function automatic logic [WORD_W-1:0] rot_r(input logic [WORD_W-1:0] v, input int n);
    return (v >> n) | (v << (WORD_W - n));
  endfunction

  // one round: constant injection, bitsliced 5-bit substitution, word diffusion
  function automatic state_t round_fn(input state_t s, input logic [RND_W-1:0] idx);
    logic [WORD_W-1:0] a0, a1, a2, a3, a4, b0, b1, b2, b3, b4;
    state_t r;
    a0 = s[0]; a1 = s[1]; a3 = s[3]; a4 = s[4];
    a2 = s[2] ^ {{(WORD_W-8){1'b0}}, ~idx, idx};
    a0 = a0 ^ a4;
    a4 = a4 ^ a3;
    a2 = a2 ^ a1;
    b0 = a0 ^ (~a1 & a2);
    b1 = a1 ^ (~a2 & a3);
    b2 = a2 ^ (~a3 & a4);
    b3 = a3 ^ (~a4 & a0);
    b4 = a4 ^ (~a0 & a1);
    b1 = b1 ^ b0;
    b0 = b0 ^ b4;
    b3 = b3 ^ b2;
    b2 = ~b2;
    r[0] = b0 ^ rot_r(b0, 19) ^ rot_r(b0, 28);
    r[1] = b1 ^ rot_r(b1, 61) ^ rot_r(b1, 39);
    r[2] = b2 ^ rot_r(b2, 1)  ^ rot_r(b2, 6);
    r[3] = b3 ^ rot_r(b3, 10) ^ rot_r(b3, 17);
    r[4] = b4 ^ rot_r(b4, 7)  ^ rot_r(b4, 41);
    return r;
  endfunction

  function automatic state_t perm_full(input state_t s);
    state_t t;
    t = s;
    for (int i = 0; i < FULL_ROUNDS; i++) t = round_fn(t, RND_W'(i));
    return t;
  endfunction

  function automatic state_t seed_state(input logic xof, input logic fast, input int fast_rounds);
    state_t s;
    logic [7:0] gap;
    gap  = fast ? 8'(FULL_ROUNDS - fast_rounds) : 8'd0;
    s    = '0;
    s[0] = {8'h00, 8'(WORD_W), 8'(FULL_ROUNDS), gap, (xof ? 32'd0 : 32'd256)};
    return s;
  endfunction
endpackage

// File: rtl/sponge_round.sv
module sponge_round
  import sponge_pkg::*;
(
  input  state_t               din,
  input  logic [RND_W-1:0]     idx,
  output state_t               dout
);
  assign dout = round_fn(din, idx);
endmodule

// File: rtl/sponge_pad.sv
module sponge_pad
  import sponge_pkg::*;
(
  input  logic [WORD_W-1:0] data,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic              last,
  output logic [WORD_W-1:0] block,
  output logic              full
);
  logic [CNT_W-1:0] n_eff;

  assign full  = !last || (nbytes >= CNT_W'(BLK_BYTES));
  assign n_eff = full ? CNT_W'(BLK_BYTES) : nbytes;

  for (genvar j = 0; j < BLK_BYTES; j++) begin : g_byte
    localparam int HI = WORD_W - 1 - 8 * j;
    assign block[HI -: 8] = (CNT_W'(j) < n_eff)  ? data[HI -: 8] :
                            (CNT_W'(j) == n_eff) ? 8'h80 : 8'h00;
  end
endmodule

// File: rtl/sponge_init.sv
module sponge_init
  import sponge_pkg::*;
#(
  parameter bit SKIP_INIT   = 1'b1,
  parameter int FAST_ROUNDS = 8
)(
  input  logic   xof,
  input  logic   fast,
  output state_t seed
);
  if (SKIP_INIT) begin : g_pre
    localparam state_t PRE_HS = perm_full(seed_state(1'b0, 1'b0, FAST_ROUNDS));
    localparam state_t PRE_HF = perm_full(seed_state(1'b0, 1'b1, FAST_ROUNDS));
    localparam state_t PRE_XS = perm_full(seed_state(1'b1, 1'b0, FAST_ROUNDS));
    localparam state_t PRE_XF = perm_full(seed_state(1'b1, 1'b1, FAST_ROUNDS));
    always_comb begin
      case ({xof, fast})
        2'b00:   seed = PRE_HS;
        2'b01:   seed = PRE_HF;
        2'b10:   seed = PRE_XS;
        default: seed = PRE_XF;
      endcase
    end
  end else begin : g_raw
    assign seed = seed_state(xof, fast, FAST_ROUNDS);
  end
endmodule

// File: rtl/sponge_hash_top.sv
module sponge_hash_top
  import sponge_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int FAST_ROUNDS = 8,
  parameter int HASH_WORDS  = 4,
  parameter bit SKIP_INIT   = 1'b1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_xof,
  input  logic              fast_sel,
  input  logic [LEN_W-1:0]  out_words,
  output logic              busy,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [WORD_W-1:0] msg_data,
  input  logic              msg_last,
  input  logic [CNT_W-1:0]  msg_bytes,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  localparam logic [RND_W-1:0] LAST_RND   = RND_W'(FULL_ROUNDS - 1);
  localparam logic [RND_W-1:0] FAST_FIRST = RND_W'(FULL_ROUNDS - FAST_ROUNDS);
  localparam logic [LEN_W-1:0] HASH_CNT   = LEN_W'(HASH_WORDS);

  phase_t            phase;
  next_t             after;
  state_t            st, st_rnd, seed;
  logic [RND_W-1:0]  rnd;
  logic              is_xof, is_fast;
  logic [LEN_W-1:0]  remain;
  logic [WORD_W-1:0] blk;
  logic              blk_full;
  logic [RND_W-1:0]  data_first;

  sponge_init #(.SKIP_INIT(SKIP_INIT), .FAST_ROUNDS(FAST_ROUNDS)) u_init (
    .xof(mode_xof), .fast(fast_sel), .seed(seed)
  );

  sponge_round u_round (.din(st), .idx(rnd), .dout(st_rnd));

  sponge_pad u_pad (
    .data(msg_data), .nbytes(msg_bytes), .last(msg_last),
    .block(blk), .full(blk_full)
  );

  assign data_first = is_fast ? FAST_FIRST : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      after   <= GO_ABSORB;
      st      <= '0;
      rnd     <= '0;
      is_xof  <= 1'b0;
      is_fast <= 1'b0;
      remain  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            is_xof  <= mode_xof;
            is_fast <= fast_sel;
            remain  <= !mode_xof ? HASH_CNT :
                       (out_words == '0) ? LEN_W'(1) : out_words;
            st      <= seed;
            rnd     <= '0;
            after   <= GO_ABSORB;
            phase   <= SKIP_INIT ? PH_ABSORB : PH_PERM;
          end
        end
        PH_PERM: begin
          st <= st_rnd;
          if (rnd == LAST_RND) begin
            case (after)
              GO_ABSORB: phase <= PH_ABSORB;
              GO_PAD:    phase <= PH_PAD;
              default:   phase <= PH_SQUEEZE;
            endcase
          end else begin
            rnd <= rnd + 1'b1;
          end
        end
        PH_ABSORB: begin
          if (msg_valid) begin
            st[0] <= st[0] ^ blk;
            phase <= PH_PERM;
            if (!msg_last) begin
              rnd   <= data_first;
              after <= GO_ABSORB;
            end else if (blk_full) begin
              rnd   <= data_first;
              after <= GO_PAD;
            end else begin
              rnd   <= '0;
              after <= GO_SQUEEZE;
            end
          end
        end
        PH_PAD: begin
          st[0] <= st[0] ^ PAD_ONLY;
          rnd   <= '0;
          after <= GO_SQUEEZE;
          phase <= PH_PERM;
        end
        PH_SQUEEZE: begin
          if (out_ready) begin
            if (remain == LEN_W'(1)) begin
              phase <= PH_IDLE;
            end else begin
              remain <= remain - 1'b1;
              rnd    <= data_first;
              after  <= GO_SQUEEZE;
              phase  <= PH_PERM;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign msg_ready = (phase == PH_ABSORB);
  assign out_valid = (phase == PH_SQUEEZE);
  assign out_data  = st[0];
  assign out_last  = (phase == PH_SQUEEZE) && (remain == LEN_W'(1));

  AST_STREAMS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(msg_ready && out_valid)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R12
  AST_NO_TAIL_ROUNDS: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !busy); // R8
  AST_DIGEST_CAP: assert property (@(posedge clk) disable iff (rst)
    busy && !is_xof |-> remain <= HASH_CNT && remain != '0); // R9
  AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase == PH_PERM |-> rnd <= LAST_RND); // R11
  AST_START_LOCKED: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> is_xof == $past(is_xof) && is_fast == $past(is_fast)); // R2
endmodule

// File: tb/tb_sponge_hash_top.sv
`timescale 1ns/1ps
module tb_sponge_hash_top;
  localparam int LEN_W = 16;
  localparam int FASTR = 8;
  localparam bit SKIP  = 1'b1;
  typedef bit [63:0] w5_t [5];

  localparam bit [4:0] SB [32] = '{
    5'h04, 5'h0b, 5'h1f, 5'h14, 5'h1a, 5'h15, 5'h09, 5'h02,
    5'h1b, 5'h05, 5'h08, 5'h12, 5'h1d, 5'h03, 5'h06, 5'h1c,
    5'h1e, 5'h13, 5'h07, 5'h0e, 5'h00, 5'h0d, 5'h11, 5'h18,
    5'h10, 5'h0c, 5'h01, 5'h19, 5'h16, 5'h0a, 5'h0f, 5'h17};

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, mode_xof = 0, fast_sel = 0;
  logic [LEN_W-1:0] out_words = '0;
  logic busy, msg_ready, out_valid, out_last;
  logic msg_valid = 0, msg_last = 0, out_ready = 0;
  logic [63:0] msg_data = '0, out_data;
  logic [3:0] msg_bytes = '0;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  sponge_hash_top #(.LEN_W(LEN_W), .FAST_ROUNDS(FASTR), .SKIP_INIT(SKIP)) dut (
    .clk(clk), .rst(rst), .start(start), .mode_xof(mode_xof), .fast_sel(fast_sel),
    .out_words(out_words), .busy(busy), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_data(msg_data), .msg_last(msg_last), .msg_bytes(msg_bytes),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic bit [63:0] rr(bit [63:0] v, int n);
    return (v >> n) | (v << (64 - n));
  endfunction

  function automatic w5_t ref_round(w5_t s, int i);
    w5_t t;
    bit [4:0] v, o;
    s[2] ^= 64'((15 - i) * 16 + i);
    for (int b = 0; b < 64; b++) begin
      v = {s[0][b], s[1][b], s[2][b], s[3][b], s[4][b]};
      o = SB[v];
      t[0][b] = o[4]; t[1][b] = o[3]; t[2][b] = o[2]; t[3][b] = o[1]; t[4][b] = o[0];
    end
    t[0] = t[0] ^ rr(t[0], 19) ^ rr(t[0], 28);
    t[1] = t[1] ^ rr(t[1], 61) ^ rr(t[1], 39);
    t[2] = t[2] ^ rr(t[2], 1)  ^ rr(t[2], 6);
    t[3] = t[3] ^ rr(t[3], 10) ^ rr(t[3], 17);
    t[4] = t[4] ^ rr(t[4], 7)  ^ rr(t[4], 41);
    return t;
  endfunction

  function automatic w5_t ref_perm(w5_t s, int n);
    for (int i = 12 - n; i < 12; i++) s = ref_round(s, i);
    return s;
  endfunction

  // per-clock monitor on stream exclusivity and busy consistency
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(!(msg_ready && out_valid), "R4", "ready/valid overlap", {62'd0, msg_ready, out_valid}, 64'd0);
      if (msg_ready || out_valid) chk(busy, "R2", "busy during job", {63'd0, busy}, 64'd1);
    end
  end

  task automatic run_job(input bit xof, input bit fast, input int cnt, input int len,
                         input int seed, input bit stall, input bit poke, input string rq);
    bit [7:0] msg[$];
    bit [63:0] exp_w[$];
    w5_t s;
    bit [63:0] blk;
    int b, nw, nblk, nb, t_ref, got, lat_first;
    bit fresh;
    b = fast ? FASTR : 12;
    for (int i = 0; i < len; i++) msg.push_back(8'(seed * 7 + i * 13 + 1));
    s[0] = {8'h00, 8'h40, 8'h0c, 8'(12 - b), (xof ? 32'h0 : 32'h100)};
    for (int k = 1; k < 5; k++) s[k] = '0;
    s = ref_perm(s, 12);
    for (int k = 0; k < len / 8; k++) begin
      blk = '0;
      for (int j = 0; j < 8; j++) blk[63 - 8 * j -: 8] = msg[8 * k + j];
      s[0] ^= blk;
      s = ref_perm(s, b);
    end
    blk = '0;
    for (int j = 0; j < len % 8; j++) blk[63 - 8 * j -: 8] = msg[8 * (len / 8) + j];
    blk[63 - 8 * (len % 8) -: 8] = 8'h80;
    s[0] ^= blk;
    s = ref_perm(s, 12);
    nw = xof ? ((cnt == 0) ? 1 : cnt) : 4;
    for (int w = 0; w < nw; w++) begin
      exp_w.push_back(s[0]);
      if (w < nw - 1) s = ref_perm(s, b);
    end

    @(negedge clk);
    start = 1; mode_xof = xof; fast_sel = fast; out_words = LEN_W'(cnt);
    t_ref = cyc;
    @(negedge clk);
    if (poke) begin
      start = 1; mode_xof = !xof; fast_sel = !fast; out_words = LEN_W'(1);
      @(negedge clk);
    end
    start = 0; mode_xof = 0; fast_sel = 0; out_words = '0;

    nblk = (len == 0) ? 1 : (len + 7) / 8;
    for (int k = 0; k < nblk; k++) begin
      nb = (k == nblk - 1) ? (len - 8 * k) : 8;
      blk = '0;
      for (int j = 0; j < 8; j++)
        blk[63 - 8 * j -: 8] = (j < nb) ? msg[8 * k + j] : (8'hA5 ^ 8'(j));
      msg_valid = 1; msg_data = blk; msg_last = (k == nblk - 1); msg_bytes = 4'(nb);
      while (!msg_ready) @(negedge clk);
      if (k == 0) begin
        if (!poke) chk(cyc - t_ref == (SKIP ? 1 : 13), "R3", "start to ready gap", 64'(cyc - t_ref), SKIP ? 64'd1 : 64'd13);
      end else begin
        chk(cyc - t_ref == b + 1, fast ? "R11" : "R4", "block to ready gap", 64'(cyc - t_ref), 64'(b + 1));
      end
      t_ref = cyc;
      @(negedge clk);
      msg_valid = 0; msg_last = 0; msg_bytes = '0;
    end

    lat_first = (len > 0 && len % 8 == 0) ? b + 14 : 13;
    got = 0; fresh = 1;
    while (got < nw) begin
      out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      if (out_valid) begin
        if (fresh) begin
          if (got == 0)
            chk(cyc - t_ref == lat_first, (lat_first == 13) ? "R7" : "R6", "last block to first word gap", 64'(cyc - t_ref), 64'(lat_first));
          else
            chk(cyc - t_ref == b + 1, "R8", "word to word gap", 64'(cyc - t_ref), 64'(b + 1));
          fresh = 0;
        end
        chk(out_data == exp_w[got], stall ? "R12" : rq, "output word", out_data, exp_w[got]);
        chk(out_last == (got == nw - 1), xof ? "R10" : "R9", "last flag", {63'd0, out_last}, {63'd0, got == nw - 1});
        if (out_ready) begin got++; t_ref = cyc; fresh = 1; end
      end
      @(negedge clk);
    end
    out_ready = 0;
    chk(!busy && !out_valid, "R8", "idle after final word", {62'd0, busy, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !msg_ready && !out_valid, "R1", "reset outputs", {61'd0, busy, msg_ready, out_valid}, 64'd0);
    run_job(1'b0, 1'b0, 0, 0,  1, 1'b0, 1'b0, "R5");   // empty message, digest
    run_job(1'b0, 1'b0, 0, 5,  2, 1'b0, 1'b0, "R5");   // partial last with junk tail bytes
    run_job(1'b0, 1'b0, 0, 16, 3, 1'b0, 1'b0, "R6");   // full last block
    run_job(1'b0, 1'b1, 0, 13, 4, 1'b0, 1'b0, "R11");  // fast variant
    run_job(1'b1, 1'b0, 3, 8,  5, 1'b0, 1'b0, "R10");  // extendable, 3 words
    run_job(1'b1, 1'b1, 0, 3,  6, 1'b0, 1'b0, "R10");  // zero request gives one word
    run_job(1'b1, 1'b0, 6, 21, 7, 1'b1, 1'b0, "R10");  // back-pressure on output
    run_job(1'b0, 1'b1, 0, 24, 8, 1'b1, 1'b1, "R2");   // start during job is ignored
    run_job(1'b0, 1'b0, 0, 7,  9, 1'b0, 1'b0, "R3");   // precomputed start matches
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule